// File: doc/BRIEF.md
# Asynchronous Receive Break Detector

This block sits after the deframing stage of an asynchronous serial receiver. For every completed frame it gets the data bits, the received parity bit and the sampled stop bits. It decides whether the frame is an ordinary character, a character with a framing error, or a line break. A break is a frame in which every sampled position is low: the active data bits, the parity bit when parity is on, and every selected stop bit. A break frame is not pushed into the receive FIFO. The block raises a break interrupt pulse if that interrupt is enabled, and then enters a break state.

While in the break state, any frames the deframer reports are discarded. The block also holds its start-acceptance output low, so the receiver does not hunt for new start bits. The break state ends on the first bit tick at which the sampled line reads high. That tick produces a single break-terminated pulse and re-enables start detection. A framing error on a character that is not all-zero is passed on with the push as an ordinary framing error.

Top module: `brk_detect`

## Requirements
- R1: After reset, `push`, `push_fe`, `brk_irq` and `brkt_irq` are 0 and `start_allow` is 1.
- R2: A frame reported by `frame_vld` outside the break state that is not a break produces, on the next cycle, a one-cycle `push` and no `brk_irq`.
- R3: A frame is a break when three things hold: the active data bits are all 0, the parity bit is 0 or `cfg_par_en`=0, and `frame_stop[0]`=0 and also `frame_stop[1]`=0 when `cfg_stop2`=1. A break frame gives no `push`, and `start_allow` reads 0 from the next cycle on.
- R4: A break frame gives a one-cycle `brk_irq` on the next cycle when `brk_irq_en`=1. It gives none when `brk_irq_en`=0.
- R5: `cfg_len` selects the character length 5 + `cfg_len` (codes 0..3 give 5..8 bits), counted from `frame_data[0]`. Data bits above that length are ignored when testing for a break.
- R6: With `cfg_par_en`=1 a parity bit of 1 prevents a break. With `cfg_par_en`=0 the parity input is ignored.
- R7: With `cfg_stop2`=1 both stop bits must be 0 for a break. If exactly one of them is 0, the frame is pushed with `push_fe`=1. With `cfg_stop2`=0, `frame_stop[1]` is ignored.
- R8: A frame that is not a break has `push_fe`=1 on its push exactly when a selected stop bit is 0.
- R9: In the break state, `frame_vld` produces no `push`, `push_fe` or `brk_irq`.
- R10: In the break state, the first cycle with `bit_tick`=1 and `rx_line`=1 produces a one-cycle `brkt_irq` on the next cycle, and `start_allow` returns to 1 at the same time. A high line without a tick, or a tick with a low line, keeps the break state.
- R11: An all-zero character whose stop bits are valid is pushed normally with `push_fe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Sampled receive line level |
| bit_tick | input | 1 | One-cycle strobe at each bit sampling point |
| cfg_len | input | 2 | Character length code, length = 5 + code |
| cfg_par_en | input | 1 | Parity bit present in the frame |
| cfg_stop2 | input | 1 | Two stop bits selected |
| brk_irq_en | input | 1 | Break interrupt enable |
| frame_vld | input | 1 | One-cycle strobe: a frame has been deframed |
| frame_data | input | 8 | Received data bits, LSB first bit |
| frame_par | input | 1 | Received parity bit value |
| frame_stop | input | 2 | Sampled stop bits, [0] first, [1] second |
| push | output | 1 | FIFO write qualifier for the frame |
| push_fe | output | 1 | Framing error flag accompanying the push |
| start_allow | output | 1 | Receiver may accept a new start bit |
| brk_irq | output | 1 | Break detected interrupt pulse |
| brkt_irq | output | 1 | Break terminated interrupt pulse |

## Verification
The assertions assume that `frame_vld` and `bit_tick` are single-cycle strobes, and that the configuration inputs are stable while a frame is being reported. The bench drives each strobe for exactly one cycle, at the falling edge. It changes the configuration only between frames, and it never reports a frame in the same cycle as a terminating tick. Random frames lean towards all-zero low bits with random high bits, so that breaks, near-breaks and framing errors all occur often.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_CHAR = 5;
    localparam int LEN_W    = 2;
    localparam int STOP_N   = 2;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             par_en;
        logic             stop2;
    } frame_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
        logic [STOP_N-1:0] stop;
    } frame_t;

    typedef enum logic [1:0] {
        FR_GOOD    = 2'd0,
        FR_FRAMING = 2'd1,
        FR_BREAK   = 2'd2
    } frame_cls_t;

    function automatic logic [DATA_W-1:0] char_mask(input logic [LEN_W-1:0] len);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++)
            m[i] = (i < (MIN_CHAR + int'(len)));
        return m;
    endfunction

endpackage

// File: rtl/brk_frame_eval.sv
module brk_frame_eval
    import brk_pkg::*;
(
    input  frame_cfg_t cfg,
    input  frame_t     frm,
    output frame_cls_t cls
);
    logic data_low;
    logic par_low;
    logic stop_all_low;
    logic stop_any_low;

    always_comb begin
        data_low     = ((frm.data & char_mask(cfg.len)) == '0);
        par_low      = !cfg.par_en || !frm.par;
        stop_all_low = !frm.stop[0] && (!cfg.stop2 || !frm.stop[1]);
        stop_any_low = !frm.stop[0] || (cfg.stop2 && !frm.stop[1]);
        if (data_low && par_low && stop_all_low)
            cls = FR_BREAK;
        else if (stop_any_low)
            cls = FR_FRAMING;
        else
            cls = FR_GOOD;
    end
endmodule

// File: rtl/brk_line_state.sv
module brk_line_state (
    input  logic clk,
    input  logic rst,
    input  logic enter_brk,
    input  logic bit_tick,
    input  logic rx_line,
    output logic in_brk,
    output logic brkt_pulse
);
    typedef enum logic {ST_HUNT, ST_BREAK} line_st_t;
    line_st_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_HUNT;
            brkt_pulse <= 1'b0;
        end else begin
            brkt_pulse <= 1'b0;
            case (st)
                ST_HUNT:  if (enter_brk) st <= ST_BREAK;
                ST_BREAK: if (bit_tick && rx_line) begin
                    st         <= ST_HUNT;
                    brkt_pulse <= 1'b1;
                end
                default:  st <= ST_HUNT;
            endcase
        end
    end

    assign in_brk = (st == ST_BREAK);
endmodule

// File: rtl/brk_detect.sv
module brk_detect
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              bit_tick,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_stop2,
    input  logic              brk_irq_en,
    input  logic              frame_vld,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              frame_par,
    input  logic [STOP_N-1:0] frame_stop,
    output logic              push,
    output logic              push_fe,
    output logic              start_allow,
    output logic              brk_irq,
    output logic              brkt_irq
);
    frame_cfg_t cfg;
    frame_t     frm;
    frame_cls_t cls;
    logic       in_brk;
    logic       take;
    logic       enter_brk;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, stop2: cfg_stop2};
    assign frm = '{data: frame_data, par: frame_par, stop: frame_stop};

    brk_frame_eval u_eval (
        .cfg (cfg),
        .frm (frm),
        .cls (cls)
    );

    assign take      = frame_vld && !in_brk;
    assign enter_brk = take && (cls == FR_BREAK);

    brk_line_state u_state (
        .clk        (clk),
        .rst        (rst),
        .enter_brk  (enter_brk),
        .bit_tick   (bit_tick),
        .rx_line    (rx_line),
        .in_brk     (in_brk),
        .brkt_pulse (brkt_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            push    <= 1'b0;
            push_fe <= 1'b0;
            brk_irq <= 1'b0;
        end else begin
            push    <= take && (cls != FR_BREAK);
            push_fe <= take && (cls == FR_FRAMING);
            brk_irq <= enter_brk && brk_irq_en;
        end
    end

    assign start_allow = !in_brk;
endmodule

// File: rtl/brk_detect_chk.sv
module brk_detect_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic rx_line,
    input logic frame_vld,
    input logic push,
    input logic push_fe,
    input logic start_allow,
    input logic brk_irq,
    input logic brkt_irq
);
    // R9
    ignore_in_break_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_allow && frame_vld) |=> (!push && !brk_irq));

    // R4
    irq_sets_break_chk: assert property (@(posedge clk) disable iff (rst)
        brk_irq |-> !start_allow);

    // R2
    push_excl_irq_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> !brk_irq);

    // R8
    fe_with_push_chk: assert property (@(posedge clk) disable iff (rst)
        push_fe |-> push);

    // R10
    brkt_releases_chk: assert property (@(posedge clk) disable iff (rst)
        brkt_irq |-> (start_allow && !brk_irq));

    // R10
    brkt_single_chk: assert property (@(posedge clk) disable iff (rst)
        brkt_irq |=> !brkt_irq);

    // R10
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_allow && !(bit_tick && rx_line)) |=> (!start_allow && !brkt_irq));

    // R3
    enter_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(start_allow) |-> !push);
endmodule

bind brk_detect brk_detect_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bit_tick    (bit_tick),
    .rx_line     (rx_line),
    .frame_vld   (frame_vld),
    .push        (push),
    .push_fe     (push_fe),
    .start_allow (start_allow),
    .brk_irq     (brk_irq),
    .brkt_irq    (brkt_irq)
);

// File: tb/brk_detect_tb.sv
module brk_detect_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       bit_tick = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       brk_irq_en = 1'b1;
    logic       frame_vld = 1'b0;
    logic [7:0] frame_data = 8'h00;
    logic       frame_par = 1'b0;
    logic [1:0] frame_stop = 2'b11;
    logic       push, push_fe, start_allow, brk_irq, brkt_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit in_brk_m = 1'b0;

    always #10 clk = ~clk;

    brk_detect u_dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .bit_tick(bit_tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_stop2(cfg_stop2),
        .brk_irq_en(brk_irq_en), .frame_vld(frame_vld), .frame_data(frame_data),
        .frame_par(frame_par), .frame_stop(frame_stop), .push(push),
        .push_fe(push_fe), .start_allow(start_allow), .brk_irq(brk_irq),
        .brkt_irq(brkt_irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_break(input logic [1:0] len, input bit pe, input bit s2,
                                     input logic [7:0] d, input bit p, input logic [1:0] s);
        bit dz = 1'b1;
        for (int i = 0; i < 5 + int'(len); i++)
            if (d[i]) dz = 1'b0;
        return dz && (!pe || !p) && !s[0] && (!s2 || !s[1]);
    endfunction

    function automatic bit exp_fe(input bit s2, input logic [1:0] s);
        return !s[0] || (s2 && !s[1]);
    endfunction

    // Drive one frame, sample after the registering edge and compare.
    task automatic frame(input string req, input logic [7:0] d, input bit p, input logic [1:0] s);
        bit brk, fe;
        brk = exp_break(cfg_len, cfg_par_en, cfg_stop2, d, p, s);
        fe  = exp_fe(cfg_stop2, s);
        @(negedge clk);
        frame_vld = 1'b1; frame_data = d; frame_par = p; frame_stop = s;
        @(negedge clk);
        frame_vld = 1'b0;
        if (in_brk_m) begin
            chk(req, "push in break", int'(push), 0);
            chk(req, "brk_irq in break", int'(brk_irq), 0);
            chk(req, "start_allow in break", int'(start_allow), 0);
        end else if (brk) begin
            chk(req, "push on break", int'(push), 0);
            chk(req, "brk_irq", int'(brk_irq), int'(brk_irq_en));
            chk(req, "start_allow after break", int'(start_allow), 0);
            in_brk_m = 1'b1;
        end else begin
            chk(req, "push", int'(push), 1);
            chk(req, "push_fe", int'(push_fe), int'(fe));
            chk(req, "brk_irq none", int'(brk_irq), 0);
        end
    endtask

    task automatic tick(input string req, input bit lvl, input bit strobe);
        bit term;
        term = in_brk_m && lvl && strobe;
        @(negedge clk);
        bit_tick = strobe; rx_line = lvl;
        @(negedge clk);
        bit_tick = 1'b0; rx_line = 1'b1;
        chk(req, "brkt_irq", int'(brkt_irq), int'(term));
        if (term) in_brk_m = 1'b0;
        chk(req, "start_allow", int'(start_allow), int'(!in_brk_m));
        if (term) begin
            @(negedge clk);
            chk(req, "brkt_irq single", int'(brkt_irq), 0);
        end
    endtask

    task automatic end_break(input string req);
        tick(req, 1'b0, 1'b1);
        tick(req, 1'b1, 1'b0);
        tick(req, 1'b1, 1'b1);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_0b2c;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "push", int'(push), 0);
        chk("R1", "push_fe", int'(push_fe), 0);
        chk("R1", "brk_irq", int'(brk_irq), 0);
        chk("R1", "brkt_irq", int'(brkt_irq), 0);
        chk("R1", "start_allow", int'(start_allow), 1);

        // Directed corners
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0; brk_irq_en = 1'b1;
        frame("R2", 8'h41, 1'b0, 2'b11);
        frame("R11", 8'h00, 1'b0, 2'b11);
        frame("R8", 8'h10, 1'b0, 2'b10);
        frame("R3", 8'h00, 1'b1, 2'b10);   // R6: parity ignored when off; R7 stop[1] ignored
        chk("R3", "model in break", int'(in_brk_m), 1);
        frame("R9", 8'h55, 1'b1, 2'b11);
        frame("R9", 8'h00, 1'b0, 2'b00);
        end_break("R10");
        cfg_len = 2'd0;
        frame("R5", 8'hE0, 1'b0, 2'b00);   // upper bits beyond 5 ignored
        chk("R5", "masked break", int'(in_brk_m), 1);
        end_break("R10");
        cfg_len = 2'd2;
        frame("R5", 8'h40, 1'b0, 2'b00);   // bit 6 inside 7-bit length: framing only
        cfg_par_en = 1'b1;
        frame("R6", 8'h00, 1'b1, 2'b00);
        frame("R6", 8'h00, 1'b0, 2'b00);
        end_break("R10");
        cfg_par_en = 1'b0; cfg_stop2 = 1'b1;
        frame("R7", 8'h00, 1'b0, 2'b10);
        frame("R7", 8'h00, 1'b0, 2'b01);
        brk_irq_en = 1'b0;
        frame("R4", 8'h00, 1'b0, 2'b00);
        end_break("R10");

        // Constrained random
        for (int it = 0; it < 400; it++) begin
            logic [7:0] d;
            cfg_len    = 2'($urandom_range(0, 3));
            cfg_par_en = 1'($urandom_range(0, 1));
            cfg_stop2  = 1'($urandom_range(0, 1));
            brk_irq_en = 1'($urandom_range(0, 1));
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 1)
                d = d & ~((8'h01 << (5 + cfg_len)) - 8'h01);
            frame("R3", d, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
            if (in_brk_m) begin
                if ($urandom_range(0, 1) == 1)
                    frame("R9", 8'($urandom), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
                tick("R10", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                if (in_brk_m) tick("R10", 1'b1, 1'b1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule